// File: doc/BRIEF.md
# Three-Channel Compare-Match Watchdog

This block is a watchdog peripheral with three independent timing channels behind a small 32-bit register bus. Each channel holds a free-running up-counter that advances on a reference tick, a bite threshold and a control word. Software keeps a channel alive by writing the counter itself back to a low value. There is no separate kick register. If reset is enabled and the counter reaches the bite threshold, the channel latches a reset request.

Channel 0 has two extras. The first is a bark threshold that sets a sticky interrupt status when interrupt-enable is on. The status is cleared by writing one to it. The second is that channel 0 raises its reset request on a dedicated recovery-reset line. Channels 1 and 2 share the ordinary system-reset line.

The bus takes a word address: the upper bits select the channel and the low two bits select the register slot. Reads are combinational, and writes take effect at the clock edge.

Top module: `cmp_watchdog`

## Requirements
- R1: The word address is channel × 4 + slot. Slot 0 is the counter, slot 1 is the bite threshold, slot 3 is control, and slot 2 of channel 0 is the bark threshold. A written value reads back unchanged.
- R2: A counter rises by one at each clock edge where `tick_i` is high. It holds when `tick_i` is low, and it wraps from 0xFFFFFFFF to 0.
- R3: A bus write to a counter in the same cycle as a tick loads the written value, and the increment is lost.
- R4: Control bit 0 is interrupt-enable, bit 1 is interrupt status and bit 2 is reset-enable. On channels 1 and 2, bits 0 and 1 always read 0 and writes to them are ignored.
- R5: When reset-enable is set and the counter is unsigned greater than or equal to the bite threshold, the reset request goes high one cycle later. It stays high until `rst` is applied. A counter and bite threshold that are both 0 also fire.
- R6: The channel 0 request drives `recovery_rst_o`. The channel 1 and channel 2 requests drive `system_rst_o`.
- R7: On channel 0, interrupt-enable set with the counter greater than or equal to the bark threshold sets the status one cycle later, and `irq_o` follows the status. With interrupt-enable clear the status is never set.
- R8: Writing 1 to control bit 1 of channel 0 clears the status, and writing 0 to it has no effect. In a cycle where the bark condition still holds, setting wins over clearing.
- R9: Reads of unimplemented word addresses return 0, and writes to them change nothing. These addresses are slot 2 of channels 1 and 2, and every word above channel 2.
- R10: After `rst`, every counter and threshold is 0, every control bit is clear and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Reference tick enable; advances all counters |
| bus_we_i | input | 1 | Write strobe |
| bus_waddr_i | input | 4 | Word address (channel × 4 + slot) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_waddr_i` |
| irq_o | output | 1 | Channel 0 bark interrupt (sticky status) |
| recovery_rst_o | output | 1 | Latched recovery-reset request from channel 0 |
| system_rst_o | output | 1 | Latched system-reset request from channels 1 and 2 |

## Verification
The hardest situation to reach is a status clear that is refused. This happens when a write-one-to-clear lands while the counter still sits at or above the bark threshold, so the set must win. The stimulus holds the counter above bark with the tick stopped and issues the clear. It then rewinds the counter and clears again, checking that only the second clear takes effect. The bite comparison is also driven to its exact boundary. The bench stops the tick with the counter equal to the threshold and checks that the request rises on the following edge and no earlier. The all-zero threshold case is reached by enabling reset with both counter and bite at 0.

// File: rtl/cmpwd_pkg.sv
package cmpwd_pkg;

    localparam int DATA_W       = 32;
    localparam int SLOTS_PER_CH = 4;
    localparam int SLOT_W       = $clog2(SLOTS_PER_CH);

    // control word bit positions
    localparam int CTL_IRQ_EN   = 0;
    localparam int CTL_IRQ_STAT = 1;
    localparam int CTL_RST_EN   = 2;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_CUR  = 2'd0,
        SLOT_BITE = 2'd1,
        SLOT_BARK = 2'd2,
        SLOT_CTRL = 2'd3
    } slot_e;

    typedef struct packed {
        logic cur;
        logic bite;
        logic bark;
        logic ctrl;
    } slot_we_t;

    typedef struct packed {
        logic [DATA_W-1:0] cur;
        logic [DATA_W-1:0] bite;
        logic [DATA_W-1:0] bark;
        logic              irq_en;
        logic              irq_stat;
        logic              rst_en;
    } ch_view_t;

    function automatic slot_we_t slot_decode(input logic we, input slot_e s);
        slot_we_t r;
        r.cur  = we && (s == SLOT_CUR);
        r.bite = we && (s == SLOT_BITE);
        r.bark = we && (s == SLOT_BARK);
        r.ctrl = we && (s == SLOT_CTRL);
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ch_view_t v);
        logic [DATA_W-1:0] w;
        w               = '0;
        w[CTL_IRQ_EN]   = v.irq_en;
        w[CTL_IRQ_STAT] = v.irq_stat;
        w[CTL_RST_EN]   = v.rst_en;
        return w;
    endfunction

endpackage

// File: rtl/cmpwd_channel.sv
module cmpwd_channel
    import cmpwd_pkg::*;
#(
    parameter bit HAS_BARK = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  slot_we_t          we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ch_view_t          view_o,
    output logic              req_o
);

    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] bite_q;
    logic [DATA_W-1:0] bark_q;
    logic              irq_en_q;
    logic              stat_q;
    logic              rst_en_q;
    logic              req_q;
    logic              bite_hit;

    assign bite_hit = rst_en_q && (cur_q >= bite_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            bite_q   <= '0;
            rst_en_q <= 1'b0;
            req_q    <= 1'b0;
        end else begin
            // a bus write overrides the tick increment
            if (we_i.cur)
                cur_q <= wdata_i;
            else if (tick_i)
                cur_q <= cur_q + DATA_W'(1);
            if (we_i.bite)
                bite_q <= wdata_i;
            if (we_i.ctrl)
                rst_en_q <= wdata_i[CTL_RST_EN];
            if (bite_hit)
                req_q <= 1'b1;
        end
    end

    generate
        if (HAS_BARK) begin : g_bark
            logic bark_hit;
            assign bark_hit = irq_en_q && (cur_q >= bark_q);

            always_ff @(posedge clk) begin
                if (rst) begin
                    bark_q   <= '0;
                    irq_en_q <= 1'b0;
                    stat_q   <= 1'b0;
                end else begin
                    if (we_i.bark)
                        bark_q <= wdata_i;
                    if (we_i.ctrl)
                        irq_en_q <= wdata_i[CTL_IRQ_EN];
                    // set has priority over write-one-to-clear
                    if (bark_hit)
                        stat_q <= 1'b1;
                    else if (we_i.ctrl && wdata_i[CTL_IRQ_STAT])
                        stat_q <= 1'b0;
                end
            end
        end else begin : g_no_bark
            assign bark_q   = '0;
            assign irq_en_q = 1'b0;
            assign stat_q   = 1'b0;
        end
    endgenerate

    assign view_o = '{cur: cur_q, bite: bite_q, bark: bark_q,
                      irq_en: irq_en_q, irq_stat: stat_q, rst_en: rst_en_q};
    assign req_o  = req_q;

endmodule

// File: rtl/cmpwd_regif.sv
module cmpwd_regif
    import cmpwd_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4
) (
    input  logic                  bus_we_i,
    input  logic [ADDR_W-1:0]     bus_waddr_i,
    input  ch_view_t [NUM_CH-1:0] views_i,
    output slot_we_t [NUM_CH-1:0] we_o,
    output logic [DATA_W-1:0]     rdata_o
);

    localparam int CH_W = ADDR_W - SLOT_W;

    logic [CH_W-1:0] ch_idx;
    slot_e           slot;

    assign ch_idx = bus_waddr_i[ADDR_W-1:SLOT_W];
    assign slot   = slot_e'(bus_waddr_i[SLOT_W-1:0]);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
            assign we_o[g] = slot_decode(bus_we_i && (ch_idx == CH_W'(g)), slot);
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CH_W'(i)) begin
                case (slot)
                    SLOT_CUR:  rdata_o = views_i[i].cur;
                    SLOT_BITE: rdata_o = views_i[i].bite;
                    SLOT_BARK: rdata_o = views_i[i].bark;
                    SLOT_CTRL: rdata_o = pack_ctrl(views_i[i]);
                    default:   rdata_o = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/cmp_watchdog.sv
module cmp_watchdog
    import cmpwd_pkg::*;
#(
    parameter  int NUM_CH = 3,
    localparam int ADDR_W = $clog2(NUM_CH) + SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_waddr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              recovery_rst_o,
    output logic              system_rst_o
);

    ch_view_t [NUM_CH-1:0] views;
    slot_we_t [NUM_CH-1:0] slot_we;
    logic     [NUM_CH-1:0] req;

    cmpwd_regif #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .bus_we_i    (bus_we_i),
        .bus_waddr_i (bus_waddr_i),
        .views_i     (views),
        .we_o        (slot_we),
        .rdata_o     (bus_rdata_o)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            cmpwd_channel #(
                .HAS_BARK (g == 0)
            ) u_ch (
                .clk     (clk),
                .rst     (rst),
                .tick_i  (tick_i),
                .we_i    (slot_we[g]),
                .wdata_i (bus_wdata_i),
                .view_o  (views[g]),
                .req_o   (req[g])
            );
        end
    endgenerate

    always_comb begin
        system_rst_o = 1'b0;
        for (int i = 1; i < NUM_CH; i++)
            system_rst_o = system_rst_o | req[i];
    end

    assign recovery_rst_o = req[0];
    assign irq_o          = views[0].irq_stat;

endmodule

// File: rtl/cmpwd_checker.sv
module cmpwd_checker #(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_waddr_i,
    input logic [31:0]       bus_wdata_i,
    input logic [31:0]       bus_rdata_o,
    input logic              irq_o,
    input logic              recovery_rst_o,
    input logic              system_rst_o
);

    logic cur_slot;
    logic hole;

    assign cur_slot = (bus_waddr_i[1:0] == 2'd0) && (int'(bus_waddr_i[ADDR_W-1:2]) < NUM_CH);
    assign hole     = (int'(bus_waddr_i[ADDR_W-1:2]) >= NUM_CH)
                   || ((bus_waddr_i[1:0] == 2'd2) && (bus_waddr_i[ADDR_W-1:2] != '0));

    AST_RECOVERY_STICKY: assert property (@(posedge clk) disable iff (rst)
        recovery_rst_o |=> recovery_rst_o); // R5

    AST_SYSTEM_STICKY: assert property (@(posedge clk) disable iff (rst)
        system_rst_o |=> system_rst_o); // R5

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !(bus_we_i && bus_waddr_i == ADDR_W'(3) && bus_wdata_i[1])) |=> irq_o); // R8

    AST_CUR_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && cur_slot) ##1 (bus_waddr_i == $past(bus_waddr_i))
        |-> (bus_rdata_o == $past(bus_wdata_i))); // R3

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
        (!bus_we_i && tick_i && cur_slot) ##1 (bus_waddr_i == $past(bus_waddr_i))
        |-> (bus_rdata_o == $past(bus_rdata_o) + 32'd1)); // R2

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        hole |-> (bus_rdata_o == 32'd0)); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_o && !recovery_rst_o && !system_rst_o)); // R10

endmodule

bind cmp_watchdog cmpwd_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .tick_i         (tick_i),
    .bus_we_i       (bus_we_i),
    .bus_waddr_i    (bus_waddr_i),
    .bus_wdata_i    (bus_wdata_i),
    .bus_rdata_o    (bus_rdata_o),
    .irq_o          (irq_o),
    .recovery_rst_o (recovery_rst_o),
    .system_rst_o   (system_rst_o)
);

// File: tb/cmp_watchdog_tb_top.sv
module cmp_watchdog_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  waddr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq, rec, sys;

    always #10 clk = ~clk; // 50 MHz

    cmp_watchdog dut_i (
        .clk            (clk),
        .rst            (rst),
        .tick_i         (tick),
        .bus_we_i       (we),
        .bus_waddr_i    (waddr),
        .bus_wdata_i    (wdata),
        .bus_rdata_o    (rdata),
        .irq_o          (irq),
        .recovery_rst_o (rec),
        .system_rst_o   (sys)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R10";

    // behavioural reference model
    logic [31:0] m_cur [3];
    logic [31:0] m_bite [3];
    logic [31:0] m_bark;
    bit          m_ien, m_stat;
    bit          m_ren [3];
    bit          m_req [3];

    always @(posedge clk) begin : model
        bit hit_b [3];
        bit hit_k;
        if (rst) begin
            for (int c = 0; c < 3; c++) begin
                m_cur[c] = 0; m_bite[c] = 0; m_ren[c] = 0; m_req[c] = 0;
            end
            m_bark = 0; m_ien = 0; m_stat = 0;
        end else begin
            for (int c = 0; c < 3; c++) hit_b[c] = m_ren[c] && (m_cur[c] >= m_bite[c]);
            hit_k = m_ien && (m_cur[0] >= m_bark);
            for (int c = 0; c < 3; c++) if (hit_b[c]) m_req[c] = 1;
            if (hit_k) m_stat = 1;
            else if (we && waddr == 4'd3 && wdata[1]) m_stat = 0;
            for (int c = 0; c < 3; c++) begin
                if (we && waddr == 4'(c * 4)) m_cur[c] = wdata;
                else if (tick) m_cur[c] = m_cur[c] + 1;
                if (we && waddr == 4'(c * 4 + 1)) m_bite[c] = wdata;
                if (we && waddr == 4'(c * 4 + 3)) begin
                    m_ren[c] = wdata[2];
                    if (c == 0) m_ien = wdata[0];
                end
            end
            if (we && waddr == 4'd2) m_bark = wdata;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        int ch = int'(a[3:2]);
        if (ch >= 3) return 0;
        case (a[1:0])
            2'd0: return m_cur[ch];
            2'd1: return m_bite[ch];
            2'd2: return (ch == 0) ? m_bark : 32'd0;
            default: return {29'd0, m_ren[ch], (ch == 0) ? m_stat : 1'b0, (ch == 0) ? m_ien : 1'b0};
        endcase
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    // model comparison, every cycle, three quarters into the cycle
    always @(negedge clk) begin
        #5;
        if (!rst) begin
            check("rdata(model)", rdata, exp_rd(waddr));
            check("irq(model)", {31'd0, irq}, {31'd0, m_stat});
            check("recovery(model)", {31'd0, rec}, {31'd0, m_req[0]});
            check("system(model)", {31'd0, sys}, {31'd0, m_req[1] | m_req[2]});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; waddr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk); waddr = a;
        #2 check($sformatf("read @%0d", a), rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; tick = 1'b0; we = 1'b0;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R10: reset values
        phase = "R10";
        for (int a = 0; a < 16; a++) rd_expect(4'(a), 32'd0);
        check("outputs after reset", {29'd0, irq, rec, sys}, 32'd0);

        // R1: address map and readback
        phase = "R1";
        wr(4'd0, 32'h11); wr(4'd1, 32'h21); wr(4'd2, 32'h33);
        wr(4'd4, 32'hA1); wr(4'd5, 32'hB1);
        wr(4'd8, 32'hA2); wr(4'd9, 32'hB2);
        rd_expect(4'd0, 32'h11); rd_expect(4'd1, 32'h21); rd_expect(4'd2, 32'h33);
        rd_expect(4'd4, 32'hA1); rd_expect(4'd5, 32'hB1);
        rd_expect(4'd8, 32'hA2); rd_expect(4'd9, 32'hB2);

        // R9: holes ignore writes and read zero
        phase = "R9";
        wr(4'd6, 32'hDEAD); wr(4'd10, 32'hBEEF); wr(4'd13, 32'h1234); wr(4'd15, 32'h7);
        rd_expect(4'd6, 0); rd_expect(4'd10, 0); rd_expect(4'd13, 0); rd_expect(4'd15, 0);
        rd_expect(4'd2, 32'h33);
        rd_expect(4'd11, 0);

        // R4: control bit positions, channel 1 lacks bits 0 and 1
        phase = "R4";
        wr(4'd7, 32'h7);
        rd_expect(4'd7, 32'h4);
        wr(4'd7, 32'h0);
        wr(4'd3, 32'h1);
        rd_expect(4'd3, 32'h1);
        wr(4'd3, 32'h0);

        // R2: tick increments and wrap
        phase = "R2";
        wr(4'd4, 32'd100);
        ticks(7);
        rd_expect(4'd4, 32'd107);
        idle(3);
        rd_expect(4'd4, 32'd107);
        wr(4'd8, 32'hFFFF_FFFE);
        ticks(3);
        rd_expect(4'd8, 32'd1);

        // R3: write beats tick
        phase = "R3";
        @(negedge clk); tick = 1'b1;
        wr(4'd4, 32'd5);
        tick = 1'b0;
        #2 check("counter after write+tick", rdata, 32'd5);

        // R5 / R6: channel 1 bite boundary and latching
        do_reset();
        phase = "R5";
        wr(4'd5, 32'd10); wr(4'd7, 32'h4);
        ticks(10);
        #2 check("system before boundary edge", {31'd0, sys}, 32'd0);
        idle(1);
        #2 check("system after boundary edge", {31'd0, sys}, 32'd1);
        phase = "R6";
        check("recovery stays low for ch1", {31'd0, rec}, 32'd0);
        phase = "R5";
        wr(4'd4, 32'd0);
        idle(2);
        #2 check("system latched after service", {31'd0, sys}, 32'd1);
        do_reset();
        phase = "R10";
        #2 check("system cleared by reset", {31'd0, sys}, 32'd0);

        // R6: channel 0 goes to recovery line
        phase = "R6";
        wr(4'd1, 32'd3); wr(4'd3, 32'h4);
        ticks(3);
        idle(1);
        #2 check("recovery from ch0", {31'd0, rec}, 32'd1);
        check("system quiet for ch0", {31'd0, sys}, 32'd0);

        // R5: zero bite and zero counter fire
        do_reset();
        phase = "R5";
        wr(4'd9, 32'd50); wr(4'd11, 32'h4);
        idle(2);
        #2 check("ch2 quiet below bite", {31'd0, sys}, 32'd0);
        wr(4'd9, 32'd0); wr(4'd8, 32'd0);
        #2 check("ch2 zero/zero fires", {31'd0, sys}, 32'd1);

        // R7 / R8: bark status and write-one-to-clear
        do_reset();
        phase = "R7";
        wr(4'd2, 32'd4); wr(4'd3, 32'h1);
        ticks(4);
        #2 check("irq not before edge", {31'd0, irq}, 32'd0);
        idle(1);
        #2 check("irq after bark", {31'd0, irq}, 32'd1);
        rd_expect(4'd3, 32'h3);
        phase = "R8";
        wr(4'd3, 32'h1);
        #2 check("write 0 to status keeps it", {31'd0, irq}, 32'd1);
        wr(4'd3, 32'h3);
        #2 check("clear refused while condition holds", {31'd0, irq}, 32'd1);
        wr(4'd0, 32'd0);
        wr(4'd3, 32'h3);
        #2 check("clear accepted below bark", {31'd0, irq}, 32'd0);
        rd_expect(4'd3, 32'h1);
        phase = "R7";
        wr(4'd3, 32'h0);
        wr(4'd0, 32'd10);
        idle(3);
        #2 check("no status with irq disabled", {31'd0, irq}, 32'd0);
        rd_expect(4'd3, 32'h0);

        idle(2);
        finish_run();
    end

endmodule